// File: doc/BRIEF.md
# Two-Layer Window Compositor

This block builds one output pixel per cycle for the visible part of a display frame out of two stacked layers. Layer 0 is the base and layer 1 is drawn over it. Each layer covers a rectangle on the screen given by two corners, and both corners are inside the rectangle. Each layer also has an enable and a pixel-format code. The formats cover a 16-bit 5-6-5 packing, four 24-bit packings with a padding byte, and four 32-bit packings that carry alpha.

Each cycle the caller presents the current screen position, a valid strobe and one fetched word from each layer's stream. Two cycles later the block returns an RGB888 value. Layer 0 is blended over black and layer 1 is blended over that result. The blend factor for each channel comes from a fixed per-layer register, or from the pixel's own alpha when that is selected for a format that carries alpha. Layer 1 also has a colour key. A pixel that matches the key is either dropped, so that layer 0 shows through, or blended with a second fixed factor. Fetching pixels and generating addresses are handled elsewhere.

Top module: `ovl_blend`

## Requirements
- R1: While reset is asserted, `out_valid_o` is 0 and `out_rgb_o` is 0.
- R2: A position covered by no enabled layer produces 0x000000. A disabled layer never contributes, even where its rectangle covers the position.
- R3: A layer covers position (x,y) exactly when tl_x ≤ x ≤ br_x and tl_y ≤ y ≤ br_y, both corners included. A rectangle whose top-left corner lies past its bottom-right corner covers nothing.
- R4: Where both layers cover a position, layer 1 is composed over the layer-0 result.
- R5: Format 0 takes R from bits 15:11, G from bits 10:5 and B from bits 4:0. Each field is widened to 8 bits by repeating its top bits below it: R8={R5,R5[4:2]}, G8={G6,G6[5:4]}, B8={B5,B5[4:2]}.
- R6: Formats 1 to 4 carry no alpha. Their channel bytes are: code 1 R[23:16] G[15:8] B[7:0]; code 2 B[23:16] G[15:8] R[7:0]; code 3 R[31:24] G[23:16] B[15:8]; code 4 B[31:24] G[23:16] R[15:8].
- R7: Formats 5 to 8 carry alpha: code 5 A[31:24] R G B; code 6 A[31:24] B G R; code 7 R G B A[7:0]; code 8 B G R A[7:0]. The colour bytes go from high to low in the order listed. When the layer's pixel-alpha select is 1, the pixel alpha is the blend factor for all three channels.
- R8: For formats 0 to 4 the pixel-alpha select has no effect. The fixed per-channel factor (layer "alpha1" input, R in bits 23:16, G in 15:8, B in 7:0) is used.
- R9: Each channel is computed as (src·a + dst·(255−a) + 127) / 255 with integer division. dst is black for layer 0, and for layer 1 it is the layer-0 result.
- R10: With key enable set, a key match occurs when ((P ^ key_color) & ~key_mask) is 0 over 24 bits. P is the unpacked RGB888 of layer 1 when the direction bit is 0 and of layer 0 when it is 1. On a match with key-blend 0, layer 1 is transparent at that position.
- R11: On a key match with key-blend 1, layer 1 is blended with the fixed "alpha0" factor of layer 1. This overrides both the pixel alpha and alpha1.
- R12: Output is valid exactly two cycles after an input with `px_valid_i` set. When `out_valid_o` is 0, `out_rgb_o` is 0.
- R13: Format codes 9 to 15 are unpacked as code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| px_valid_i | input | 1 | Current position and pixel words are valid |
| scr_x_i | input | X_W | Screen column |
| scr_y_i | input | Y_W | Screen row |
| w0_pix_i | input | 32 | Layer 0 fetched word |
| w1_pix_i | input | 32 | Layer 1 fetched word |
| w0_en_i | input | 1 | Layer 0 enable |
| w1_en_i | input | 1 | Layer 1 enable |
| w0_tl_x_i | input | X_W | Layer 0 left column |
| w0_tl_y_i | input | Y_W | Layer 0 top row |
| w0_br_x_i | input | X_W | Layer 0 right column (inclusive) |
| w0_br_y_i | input | Y_W | Layer 0 bottom row (inclusive) |
| w1_tl_x_i | input | X_W | Layer 1 left column |
| w1_tl_y_i | input | Y_W | Layer 1 top row |
| w1_br_x_i | input | X_W | Layer 1 right column (inclusive) |
| w1_br_y_i | input | Y_W | Layer 1 bottom row (inclusive) |
| w0_fmt_i | input | 4 | Layer 0 format code |
| w1_fmt_i | input | 4 | Layer 1 format code |
| w0_pa_sel_i | input | 1 | Layer 0 uses pixel alpha |
| w1_pa_sel_i | input | 1 | Layer 1 uses pixel alpha |
| w0_alpha1_i | input | 24 | Layer 0 fixed per-channel factor |
| w1_alpha1_i | input | 24 | Layer 1 fixed per-channel factor |
| w1_alpha0_i | input | 24 | Layer 1 factor for keyed pixels |
| ck_en_i | input | 1 | Colour key enable |
| ck_blend_i | input | 1 | Keyed pixels blend instead of vanishing |
| ck_dir_i | input | 1 | Key compares layer 0 (1) or layer 1 (0) |
| ck_mask_i | input | 24 | Key bits to ignore |
| ck_color_i | input | 24 | Key colour |
| out_valid_o | output | 1 | Output pixel valid |
| out_rgb_o | output | 24 | Output RGB888 |

## Verification
The hardest case to reach from the ports is a key match decided by the layer-0 pixel while the position lies in the overlap of both rectangles. A match there is only visible when a partial mask hides the bits that differ and the key-blend setting chooses between dropping layer 1 and blending it at alpha0. The stimulus places positions inside the overlap on purpose and loads the key colour from the packing of the chosen layer's word. It then flips single bits inside and outside the mask, switches the direction, and finally runs a random sweep in which all these controls vary together.

// File: rtl/ovl_blend_pkg.sv
package ovl_blend_pkg;

    typedef enum logic [3:0] {
        FMT_565  = 4'd0,
        FMT_XRGB = 4'd1,
        FMT_XBGR = 4'd2,
        FMT_RGBX = 4'd3,
        FMT_BGRX = 4'd4,
        FMT_ARGB = 4'd5,
        FMT_ABGR = 4'd6,
        FMT_RGBA = 4'd7,
        FMT_BGRA = 4'd8
    } pix_fmt_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic l0_on;
        logic l1_on;
        rgb_t w0;
        rgb_t w1;
        rgb_t f0;
        rgb_t f1;
    } stage1_t;

    typedef struct packed {
        logic valid;
        rgb_t rgb;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

endpackage

// File: rtl/ovl_unpack.sv
module ovl_unpack
    import ovl_blend_pkg::*;
(
    input  logic [31:0] pix_i,
    input  logic [3:0]  fmt_i,
    output rgb_t        rgb_o,
    output logic [7:0]  alpha_o,
    output logic        has_alpha_o
);
    always_comb begin
        rgb_o       = '0;
        alpha_o     = 8'hFF;
        has_alpha_o = 1'b0;
        case (pix_fmt_e'(fmt_i))
            FMT_565: begin
                rgb_o.r = {pix_i[15:11], pix_i[15:13]};
                rgb_o.g = {pix_i[10:5],  pix_i[10:9]};
                rgb_o.b = {pix_i[4:0],   pix_i[4:2]};
            end
            FMT_XBGR: begin
                rgb_o.b = pix_i[23:16];
                rgb_o.g = pix_i[15:8];
                rgb_o.r = pix_i[7:0];
            end
            FMT_RGBX: begin
                rgb_o.r = pix_i[31:24];
                rgb_o.g = pix_i[23:16];
                rgb_o.b = pix_i[15:8];
            end
            FMT_BGRX: begin
                rgb_o.b = pix_i[31:24];
                rgb_o.g = pix_i[23:16];
                rgb_o.r = pix_i[15:8];
            end
            FMT_ARGB: begin
                alpha_o     = pix_i[31:24];
                has_alpha_o = 1'b1;
                rgb_o.r     = pix_i[23:16];
                rgb_o.g     = pix_i[15:8];
                rgb_o.b     = pix_i[7:0];
            end
            FMT_ABGR: begin
                alpha_o     = pix_i[31:24];
                has_alpha_o = 1'b1;
                rgb_o.b     = pix_i[23:16];
                rgb_o.g     = pix_i[15:8];
                rgb_o.r     = pix_i[7:0];
            end
            FMT_RGBA: begin
                rgb_o.r     = pix_i[31:24];
                rgb_o.g     = pix_i[23:16];
                rgb_o.b     = pix_i[15:8];
                alpha_o     = pix_i[7:0];
                has_alpha_o = 1'b1;
            end
            FMT_BGRA: begin
                rgb_o.b     = pix_i[31:24];
                rgb_o.g     = pix_i[23:16];
                rgb_o.r     = pix_i[15:8];
                alpha_o     = pix_i[7:0];
                has_alpha_o = 1'b1;
            end
            default: begin
                // code 1 and all unassigned codes share the padded R-G-B packing
                rgb_o.r = pix_i[23:16];
                rgb_o.g = pix_i[15:8];
                rgb_o.b = pix_i[7:0];
            end
        endcase
    end
endmodule

// File: rtl/ovl_rect_hit.sv
module ovl_rect_hit #(
    parameter int X_W = 12,
    parameter int Y_W = 12
) (
    input  logic [X_W-1:0] x_i,
    input  logic [Y_W-1:0] y_i,
    input  logic [X_W-1:0] tl_x_i,
    input  logic [Y_W-1:0] tl_y_i,
    input  logic [X_W-1:0] br_x_i,
    input  logic [Y_W-1:0] br_y_i,
    output logic           hit_o
);
    logic in_x;
    logic in_y;

    // both corners belong to the rectangle
    assign in_x  = (x_i >= tl_x_i) && (x_i <= br_x_i);
    assign in_y  = (y_i >= tl_y_i) && (y_i <= br_y_i);
    assign hit_o = in_x && in_y;
endmodule

// File: rtl/ovl_ckey.sv
module ovl_ckey
    import ovl_blend_pkg::*;
(
    input  logic        en_i,
    input  logic        dir_i,
    input  rgb_t        top_i,
    input  rgb_t        base_i,
    input  logic [23:0] mask_i,
    input  logic [23:0] color_i,
    output logic        match_o
);
    logic [23:0] probe;
    logic [23:0] diff;

    assign probe   = dir_i ? base_i : top_i;
    assign diff    = (probe ^ color_i) & ~mask_i;
    assign match_o = en_i && (diff == 24'd0);
endmodule

// File: rtl/ovl_blend_ch.sv
module ovl_blend_ch (
    input  logic [7:0] src_i,
    input  logic [7:0] dst_i,
    input  logic [7:0] alpha_i,
    output logic [7:0] mix_o
);
    logic [16:0] num;
    logic [16:0] quo;
    logic        unused_quo;

    // weighted sum with rounding offset, then exact divide by 255 for this range
    assign num = 17'(src_i) * 17'(alpha_i)
               + 17'(dst_i) * 17'(8'd255 - alpha_i)
               + 17'd127;
    assign quo = (num + (num >> 8) + 17'd1) >> 8;
    assign mix_o = quo[7:0];
    assign unused_quo = ^quo[16:8];
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
    import ovl_blend_pkg::*;
#(
    parameter int X_W = 12,
    parameter int Y_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           px_valid_i,
    input  logic [X_W-1:0] scr_x_i,
    input  logic [Y_W-1:0] scr_y_i,
    input  logic [31:0]    w0_pix_i,
    input  logic [31:0]    w1_pix_i,
    input  logic           w0_en_i,
    input  logic           w1_en_i,
    input  logic [X_W-1:0] w0_tl_x_i,
    input  logic [Y_W-1:0] w0_tl_y_i,
    input  logic [X_W-1:0] w0_br_x_i,
    input  logic [Y_W-1:0] w0_br_y_i,
    input  logic [X_W-1:0] w1_tl_x_i,
    input  logic [Y_W-1:0] w1_tl_y_i,
    input  logic [X_W-1:0] w1_br_x_i,
    input  logic [Y_W-1:0] w1_br_y_i,
    input  logic [3:0]     w0_fmt_i,
    input  logic [3:0]     w1_fmt_i,
    input  logic           w0_pa_sel_i,
    input  logic           w1_pa_sel_i,
    input  logic [23:0]    w0_alpha1_i,
    input  logic [23:0]    w1_alpha1_i,
    input  logic [23:0]    w1_alpha0_i,
    input  logic           ck_en_i,
    input  logic           ck_blend_i,
    input  logic           ck_dir_i,
    input  logic [23:0]    ck_mask_i,
    input  logic [23:0]    ck_color_i,
    output logic           out_valid_o,
    output logic [23:0]    out_rgb_o
);
    localparam int NWIN = 2;
    localparam int NCH  = 3;
    localparam int CH_W = 8;

    // per-layer views of the port groups
    logic [31:0]    win_pix [NWIN];
    logic [3:0]     win_fmt [NWIN];
    logic [X_W-1:0] win_tlx [NWIN];
    logic [Y_W-1:0] win_tly [NWIN];
    logic [X_W-1:0] win_brx [NWIN];
    logic [Y_W-1:0] win_bry [NWIN];

    assign win_pix[0] = w0_pix_i;
    assign win_pix[1] = w1_pix_i;
    assign win_fmt[0] = w0_fmt_i;
    assign win_fmt[1] = w1_fmt_i;
    assign win_tlx[0] = w0_tl_x_i;
    assign win_tlx[1] = w1_tl_x_i;
    assign win_tly[0] = w0_tl_y_i;
    assign win_tly[1] = w1_tl_y_i;
    assign win_brx[0] = w0_br_x_i;
    assign win_brx[1] = w1_br_x_i;
    assign win_bry[0] = w0_br_y_i;
    assign win_bry[1] = w1_br_y_i;

    rgb_t            up_rgb [NWIN];
    logic [7:0]      up_alpha [NWIN];
    logic [NWIN-1:0] up_has_a;
    logic [NWIN-1:0] win_hit;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            ovl_unpack u_unpack (
                .pix_i       (win_pix[w]),
                .fmt_i       (win_fmt[w]),
                .rgb_o       (up_rgb[w]),
                .alpha_o     (up_alpha[w]),
                .has_alpha_o (up_has_a[w])
            );
            ovl_rect_hit #(
                .X_W (X_W),
                .Y_W (Y_W)
            ) u_hit (
                .x_i    (scr_x_i),
                .y_i    (scr_y_i),
                .tl_x_i (win_tlx[w]),
                .tl_y_i (win_tly[w]),
                .br_x_i (win_brx[w]),
                .br_y_i (win_bry[w]),
                .hit_o  (win_hit[w])
            );
        end
    endgenerate

    logic key_match;

    ovl_ckey u_ckey (
        .en_i    (ck_en_i),
        .dir_i   (ck_dir_i),
        .top_i   (up_rgb[1]),
        .base_i  (up_rgb[0]),
        .mask_i  (ck_mask_i),
        .color_i (ck_color_i),
        .match_o (key_match)
    );

    pipe_t st_d;
    pipe_t st_q;

    // second stage: two chained blends
    logic [23:0] l0_src;
    logic [23:0] l1_src;
    logic [23:0] l0_fac;
    logic [23:0] l1_fac;
    logic [23:0] l0_mix;
    logic [23:0] l0_res;
    logic [23:0] l1_mix;

    assign l0_src = st_q.s1.w0;
    assign l1_src = st_q.s1.w1;
    assign l0_fac = st_q.s1.f0;
    assign l1_fac = st_q.s1.f1;
    assign l0_res = st_q.s1.l0_on ? l0_mix : 24'd0;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            ovl_blend_ch u_mix0 (
                .src_i   (l0_src[CH_W*c +: CH_W]),
                .dst_i   (8'd0),
                .alpha_i (l0_fac[CH_W*c +: CH_W]),
                .mix_o   (l0_mix[CH_W*c +: CH_W])
            );
            ovl_blend_ch u_mix1 (
                .src_i   (l1_src[CH_W*c +: CH_W]),
                .dst_i   (l0_res[CH_W*c +: CH_W]),
                .alpha_i (l1_fac[CH_W*c +: CH_W]),
                .mix_o   (l1_mix[CH_W*c +: CH_W])
            );
        end
    endgenerate

    always_comb begin
        logic key_hide;
        logic key_soft;

        st_d     = st_q;
        key_hide = key_match && !ck_blend_i;
        key_soft = key_match && ck_blend_i;

        // stage 1: coverage, unpacked colours and blend factors
        st_d.s1.valid = px_valid_i;
        st_d.s1.l0_on = px_valid_i && w0_en_i && win_hit[0];
        st_d.s1.l1_on = px_valid_i && w1_en_i && win_hit[1] && !key_hide;
        st_d.s1.w0    = up_rgb[0];
        st_d.s1.w1    = up_rgb[1];

        if (up_has_a[0] && w0_pa_sel_i) begin
            st_d.s1.f0 = '{r: up_alpha[0], g: up_alpha[0], b: up_alpha[0]};
        end else begin
            st_d.s1.f0 = w0_alpha1_i;
        end

        if (key_soft) begin
            st_d.s1.f1 = w1_alpha0_i;
        end else if (up_has_a[1] && w1_pa_sel_i) begin
            st_d.s1.f1 = '{r: up_alpha[1], g: up_alpha[1], b: up_alpha[1]};
        end else begin
            st_d.s1.f1 = w1_alpha1_i;
        end

        // stage 2: final pixel
        st_d.s2.valid = st_q.s1.valid;
        st_d.s2.rgb   = st_q.s1.l1_on ? l1_mix : l0_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.s2.valid;
    assign out_rgb_o   = st_q.s2.rgb;
endmodule

// File: rtl/ovl_blend_chk.sv
module ovl_blend_chk #(
    parameter int X_W = 12,
    parameter int Y_W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           px_valid_i,
    input logic [X_W-1:0] scr_x_i,
    input logic [Y_W-1:0] scr_y_i,
    input logic [31:0]    w1_pix_i,
    input logic           w0_en_i,
    input logic           w1_en_i,
    input logic [X_W-1:0] w1_tl_x_i,
    input logic [Y_W-1:0] w1_tl_y_i,
    input logic [X_W-1:0] w1_br_x_i,
    input logic [Y_W-1:0] w1_br_y_i,
    input logic [3:0]     w1_fmt_i,
    input logic [23:0]    w1_alpha1_i,
    input logic           ck_en_i,
    input logic           out_valid_o,
    input logic [23:0]    out_rgb_o
);
    logic w1_cover;
    assign w1_cover = scr_x_i >= w1_tl_x_i && scr_x_i <= w1_br_x_i &&
                      scr_y_i >= w1_tl_y_i && scr_y_i <= w1_br_y_i;

    p_idle_black_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> out_rgb_o == 24'd0);

    p_valid_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid_i |-> ##2 out_valid_o);

    p_invalid_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid_i |-> ##2 !out_valid_o);

    p_no_layer_black_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid_i && !w0_en_i && !w1_en_i) |-> ##2 out_rgb_o == 24'd0);

    p_opaque_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid_i && w1_en_i && w1_cover && !ck_en_i &&
         w1_fmt_i == 4'd1 && w1_alpha1_i == 24'hFFFFFF)
        |-> ##2 out_rgb_o == $past(w1_pix_i[23:0], 2));
endmodule

bind ovl_blend ovl_blend_chk #(
    .X_W (X_W),
    .Y_W (Y_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .px_valid_i  (px_valid_i),
    .scr_x_i     (scr_x_i),
    .scr_y_i     (scr_y_i),
    .w1_pix_i    (w1_pix_i),
    .w0_en_i     (w0_en_i),
    .w1_en_i     (w1_en_i),
    .w1_tl_x_i   (w1_tl_x_i),
    .w1_tl_y_i   (w1_tl_y_i),
    .w1_br_x_i   (w1_br_x_i),
    .w1_br_y_i   (w1_br_y_i),
    .w1_fmt_i    (w1_fmt_i),
    .w1_alpha1_i (w1_alpha1_i),
    .ck_en_i     (ck_en_i),
    .out_valid_o (out_valid_o),
    .out_rgb_o   (out_rgb_o)
);

// File: tb/ovl_blend_tb_top.sv
module ovl_blend_tb_top;
    localparam int X_W = 12;
    localparam int Y_W = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           px_valid = 1'b0;
    logic [X_W-1:0] sx = '0;
    logic [Y_W-1:0] sy = '0;
    logic [31:0]    p0 = '0, p1 = '0;
    logic           en0 = 1'b0, en1 = 1'b0;
    logic [X_W-1:0] tlx0 = 12'd10, brx0 = 12'd49, tlx1 = 12'd30, brx1 = 12'd59;
    logic [Y_W-1:0] tly0 = 12'd10, bry0 = 12'd29, tly1 = 12'd20, bry1 = 12'd39;
    logic [3:0]     fmt0 = 4'd1, fmt1 = 4'd1;
    logic           pa0 = 1'b0, pa1 = 1'b0;
    logic [23:0]    a1_0 = 24'hFFFFFF, a1_1 = 24'hFFFFFF, a0_1 = 24'h000000;
    logic           kon = 1'b0, kbl = 1'b0, kdir = 1'b0;
    logic [23:0]    kmask = '0, kcol = '0;
    logic           o_valid;
    logic [23:0]    o_rgb;

    always #4 clk = ~clk;

    ovl_blend #(.X_W(X_W), .Y_W(Y_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .px_valid_i(px_valid),
        .scr_x_i(sx), .scr_y_i(sy), .w0_pix_i(p0), .w1_pix_i(p1),
        .w0_en_i(en0), .w1_en_i(en1),
        .w0_tl_x_i(tlx0), .w0_tl_y_i(tly0), .w0_br_x_i(brx0), .w0_br_y_i(bry0),
        .w1_tl_x_i(tlx1), .w1_tl_y_i(tly1), .w1_br_x_i(brx1), .w1_br_y_i(bry1),
        .w0_fmt_i(fmt0), .w1_fmt_i(fmt1), .w0_pa_sel_i(pa0), .w1_pa_sel_i(pa1),
        .w0_alpha1_i(a1_0), .w1_alpha1_i(a1_1), .w1_alpha0_i(a0_1),
        .ck_en_i(kon), .ck_blend_i(kbl), .ck_dir_i(kdir),
        .ck_mask_i(kmask), .ck_color_i(kcol),
        .out_valid_o(o_valid), .out_rgb_o(o_rgb)
    );

    typedef struct {
        bit          v;
        logic [23:0] rgb;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    function automatic void unp(input logic [31:0] p, input logic [3:0] f,
                                output int c[3], output int a, output bit ha);
        a = 255; ha = 0;
        case (f)
            4'd0: begin
                c[0] = (int'(p[15:11]) << 3) | (int'(p[15:11]) >> 2);
                c[1] = (int'(p[10:5])  << 2) | (int'(p[10:5])  >> 4);
                c[2] = (int'(p[4:0])   << 3) | (int'(p[4:0])   >> 2);
            end
            4'd2: begin c[2] = p[23:16]; c[1] = p[15:8];  c[0] = p[7:0];  end
            4'd3: begin c[0] = p[31:24]; c[1] = p[23:16]; c[2] = p[15:8]; end
            4'd4: begin c[2] = p[31:24]; c[1] = p[23:16]; c[0] = p[15:8]; end
            4'd5: begin a = p[31:24]; ha = 1; c[0] = p[23:16]; c[1] = p[15:8]; c[2] = p[7:0]; end
            4'd6: begin a = p[31:24]; ha = 1; c[2] = p[23:16]; c[1] = p[15:8]; c[0] = p[7:0]; end
            4'd7: begin a = p[7:0]; ha = 1; c[0] = p[31:24]; c[1] = p[23:16]; c[2] = p[15:8]; end
            4'd8: begin a = p[7:0]; ha = 1; c[2] = p[31:24]; c[1] = p[23:16]; c[0] = p[15:8]; end
            default: begin c[0] = p[23:16]; c[1] = p[15:8]; c[2] = p[7:0]; end
        endcase
    endfunction

    function automatic int mixv(int s, int d, int a);
        return (s * a + d * (255 - a) + 127) / 255;
    endfunction

    function automatic exp_t model(string tag);
        exp_t e;
        int c0[3], c1[3];
        int al0, al1, probe, res, acc;
        bit h0, h1, on0, on1, match;
        e.tag = tag;
        e.v = px_valid;
        e.rgb = '0;
        if (!px_valid) return e;
        unp(p0, fmt0, c0, al0, h0);
        unp(p1, fmt1, c1, al1, h1);
        on0 = en0 && sx >= tlx0 && sx <= brx0 && sy >= tly0 && sy <= bry0;
        on1 = en1 && sx >= tlx1 && sx <= brx1 && sy >= tly1 && sy <= bry1;
        probe = kdir ? ((c0[0] << 16) | (c0[1] << 8) | c0[2])
                     : ((c1[0] << 16) | (c1[1] << 8) | c1[2]);
        match = kon && (((probe ^ int'(kcol)) & ~int'(kmask) & 'hFFFFFF) == 0);
        if (match && !kbl) on1 = 0;
        acc = 0;
        for (int c = 0; c < 3; c++) begin
            int f0, f1;
            f0 = (h0 && pa0) ? al0 : ((int'(a1_0) >> (8 * (2 - c))) & 255);
            if (match && kbl)   f1 = (int'(a0_1) >> (8 * (2 - c))) & 255;
            else if (h1 && pa1) f1 = al1;
            else                f1 = (int'(a1_1) >> (8 * (2 - c))) & 255;
            res = 0;
            if (on0) res = mixv(c0[c], 0, f0);
            if (on1) res = mixv(c1[c], res, f1);
            acc = acc | (res << (8 * (2 - c)));
        end
        e.rgb = acc[23:0];
        return e;
    endfunction

    // push the expectation for the inputs now applied, then compare the one due
    task automatic step(string tag);
        exp_t e;
        expq.push_back(model(tag));
        @(negedge clk);
        e = expq.pop_front();
        n_cmp++;
        if (o_valid !== e.v || o_rgb !== e.rgb) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b rgb=%06h, expected valid=%0b rgb=%06h",
                     e.tag, o_valid, o_rgb, e.v, e.rgb);
        end
    endtask

    task automatic at(int x, int y);
        px_valid = 1'b1; sx = X_W'(x); sy = Y_W'(y);
    endtask

    task automatic defaults();
        en0 = 0; en1 = 0; fmt0 = 4'd1; fmt1 = 4'd1; pa0 = 0; pa1 = 0;
        a1_0 = 24'hFFFFFF; a1_1 = 24'hFFFFFF; a0_1 = 24'h000000;
        kon = 0; kbl = 0; kdir = 0; kmask = '0; kcol = '0;
        tlx0 = 10; tly0 = 10; brx0 = 49; bry0 = 29;
        tlx1 = 30; tly1 = 20; brx1 = 59; bry1 = 39;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got no end of test, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        expq.push_back('{v: 1'b0, rgb: 24'd0, tag: "R12 pipe fill"});
        // R1: outputs held at zero in reset
        en0 = 1; en1 = 1; px_valid = 1; p0 = 32'h00ABCDEF; sx = 40; sy = 25;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (o_valid !== 1'b0 || o_rgb !== 24'd0) begin
            n_bad++;
            $display("FAIL R1: got valid=%0b rgb=%06h, expected valid=0 rgb=000000", o_valid, o_rgb);
        end
        px_valid = 0;
        rst_n = 1;
        defaults();

        // R12: invalid input gives zero, even over enabled layers
        en0 = 1; en1 = 1; p0 = 32'h00112233; p1 = 32'h00445566; sx = 40; sy = 25;
        px_valid = 0; step("R12 invalid");
        step("R12 invalid");

        // R2: nothing enabled / outside all rectangles
        defaults(); p0 = 32'h00FFFFFF; p1 = 32'h00FFFFFF;
        at(40, 25); step("R2 all disabled");
        en0 = 1; en1 = 1; at(5, 5); step("R2 outside");
        at(60, 40); step("R2 outside");

        // R3: inclusive corners
        defaults(); en0 = 1; p0 = 32'h00A1B2C3;
        at(49, 29); step("R3 br corner");
        at(10, 10); step("R3 tl corner");
        at(50, 29); step("R3 right of br");
        at(49, 30); step("R3 below br");
        at(9, 10);  step("R3 left of tl");
        tlx0 = 40; brx0 = 20; at(30, 15); step("R3 inverted rect");

        // R4: layer 1 above layer 0
        defaults(); en0 = 1; en1 = 1; p0 = 32'h00102030; p1 = 32'h00C0D0E0;
        at(40, 25); step("R4 overlap");
        at(20, 15); step("R4 only base");
        at(55, 35); step("R4 only top");

        // R5: 565 widening
        defaults(); en0 = 1; fmt0 = 4'd0;
        p0 = 32'h0000F81F; at(15, 15); step("R5 565");
        p0 = 32'h000007E0; step("R5 565");
        p0 = 32'hFFFF8410; step("R5 565 upper bits ignored");

        // R6: padded orderings
        defaults(); en0 = 1; p0 = 32'h11223344;
        for (int f = 1; f <= 4; f++) begin
            fmt0 = 4'(f); at(15, 15); step("R6 padded order");
        end
        // R13: unassigned codes
        for (int f = 9; f <= 15; f++) begin
            fmt0 = 4'(f); step("R13 unassigned code");
        end

        // R7: alpha orderings with pixel alpha over base layer
        defaults(); en0 = 1; en1 = 1; p0 = 32'h00204060; pa1 = 1;
        fmt1 = 4'd5; p1 = 32'h80F0A050; at(40, 25); step("R7 argb");
        fmt1 = 4'd6; step("R7 abgr");
        fmt1 = 4'd7; p1 = 32'hF0A05040; step("R7 rgba");
        fmt1 = 4'd8; step("R7 bgra");
        pa1 = 0; a1_1 = 24'h406080; step("R7 select off uses fixed");
        pa0 = 1; fmt0 = 4'd5; p0 = 32'h40FF8000; at(15, 15); step("R7 base pixel alpha");

        // R8: select ignored for non-alpha formats
        defaults(); en0 = 1; en1 = 1; p0 = 32'h00204060; pa1 = 1; pa0 = 1;
        fmt1 = 4'd1; p1 = 32'h00F0A050; at(40, 25); step("R8 xrgb select ignored");
        fmt1 = 4'd0; p1 = 32'h0000ABCD; step("R8 565 select ignored");
        fmt1 = 4'd3; p1 = 32'hF0A05000; a1_1 = 24'h80_40_C0; step("R8 rgbx fixed factor");

        // R9: fixed factor rounding
        defaults(); en0 = 1; a1_0 = 24'h80_40_01; p0 = 32'h00FF7F03; at(15, 15); step("R9 over black");
        en1 = 1; a1_1 = 24'h7F_00_FF; p1 = 32'h00FFFFFF; at(40, 25); step("R9 chained");
        a1_0 = 24'h000000; a1_1 = 24'hFFFFFF; step("R9 extremes");

        // R10: colour key
        defaults(); en0 = 1; en1 = 1; p0 = 32'h00336699; p1 = 32'h00CC9966;
        kon = 1; kcol = 24'hCC9966; at(40, 25); step("R10 exact match drops top");
        kcol = 24'hCD9966; step("R10 unmasked bit differs");
        kmask = 24'h010000; step("R10 masked bit ignored");
        kmask = 24'h0; kdir = 1; kcol = 24'h336699; step("R10 direction probes base");
        kcol = 24'hCC9966; step("R10 direction base mismatch");
        kon = 0; kcol = 24'hCC9966; kdir = 0; step("R10 disabled key");
        kon = 1; fmt1 = 4'd0; p1 = 32'h0000F81F; kcol = 24'hFF00FF; step("R10 key on widened 565");

        // R11: key blend at alpha0
        defaults(); en0 = 1; en1 = 1; p0 = 32'h00336699; p1 = 32'h80CC9966;
        fmt1 = 4'd5; pa1 = 1; kon = 1; kbl = 1; kcol = 24'hCC9966; a0_1 = 24'h40_80_C0;
        at(40, 25); step("R11 keyed blend alpha0");
        kcol = 24'h000000; step("R11 unmatched uses pixel alpha");

        // random sweep across all controls
        for (int i = 0; i < 400; i++) begin
            px_valid = ($urandom % 8) != 0;
            sx = X_W'($urandom % 64); sy = Y_W'($urandom % 48);
            p0 = $urandom; p1 = $urandom;
            en0 = $urandom; en1 = $urandom;
            fmt0 = 4'($urandom % 10); fmt1 = 4'($urandom % 10);
            pa0 = $urandom; pa1 = $urandom;
            a1_0 = 24'($urandom); a1_1 = 24'($urandom); a0_1 = 24'($urandom);
            kon = $urandom; kbl = $urandom; kdir = $urandom;
            kmask = ($urandom % 2) ? 24'hFFFF00 : 24'h0;
            kcol = ($urandom % 2) ? (kdir ? p0[23:0] : p1[23:0]) : 24'($urandom);
            step("R4 R9 R10 R11 random");
        end
        px_valid = 0;
        step("R12 drain");
        step("R12 drain");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule